// File: doc/BRIEF.md
# AES3 Subframe and Channel-Status Block Sequencer

This block sits in front of an AES3-style transmitter encoder. It places outgoing audio samples into the subframe slots and keeps the 192-frame channel status block count. The transmitter timing logic pulses `slotTick` once per subframe period. On the clock after each tick, the block presents one subframe: a 24-bit sample word, a tag that says whether the slot is subframe A or B, a user bit, and a flag that marks the first subframe of a channel status block. Line coding, preambles and parity are left to the encoder that follows.

There are two packing modes. In stereo mode, each frame carries one sample pair: the left sample in A and the right sample in B. In mono mode, both slots of a frame carry consecutive samples of a single selected channel, so the frame rate is half the sample rate. The block-start reference can be produced here (master) or taken from another transmitter or from external logic (slave), so that several encoders start their blocks on the same frame.

Top module: `aes3SubframeSeq`

## Requirements
- R1: While `rstN` is low, and until the first tick after reset, `sfValid`, `sfData`, `sfChanB`, `sfBlockStart`, `sfUser` and `blkStartOut` are all 0. The first subframe after reset is subframe A of frame 0.
- R2: Each `slotTick` cycle is followed, on the next clock, by a one-cycle `sfValid` pulse with new subframe outputs. Between ticks, `sfData`, `sfChanB`, `sfBlockStart` and `sfUser` hold their values.
- R3: The emitted subframes alternate between A (`sfChanB`=0) and B (`sfChanB`=1), starting with A.
- R4: In stereo mode (`monoMode`=0), subframe A carries `inLeft` from its tick cycle. The following subframe B carries the `inRight` value captured in that same cycle, and ignores the inputs present at the B tick.
- R5: In mono mode (`monoMode`=1), every subframe carries the current input of one channel: `inLeft` when `monoRight`=0, and `inRight` when `monoRight`=1.
- R6: `sampleTake` is high, in the tick cycle, on every stereo A slot and every mono slot. It is low on stereo B slots and whenever `slotTick` is low.
- R7: `sfBlockStart` is 1 only for subframe A of frame 0. The frame count advances after each B subframe and wraps from 191 to 0, so block starts fall 192 frames apart.
- R8: With `blockMaster`=1, `blkStartDrive` is 1 and `blkStartOut` equals `sfBlockStart`, which keeps it high for the whole first subframe. With `blockMaster`=0, both are 0.
- R9: With `blockMaster`=0, a rising edge on `extBlkStart` makes the next subframe A frame 0 (block start), and counting continues from there. With `blockMaster`=1, `extBlkStart` has no effect.
- R10: With `userZero`=1, `sfUser` is 0. Otherwise `sfUser` is the `userIn` value from the tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotTick | input | 1 | One-cycle strobe per subframe slot |
| monoMode | input | 1 | 1 selects mono packing |
| monoRight | input | 1 | Mono channel select: 0 left, 1 right |
| blockMaster | input | 1 | 1 generates block start here, 0 follows `extBlkStart` |
| extBlkStart | input | 1 | Block-start reference from outside (slave) |
| userZero | input | 1 | Forces outgoing user bits to 0 |
| userIn | input | 1 | User bit for the current slot |
| inLeft | input | 24 | Left channel sample |
| inRight | input | 24 | Right channel sample |
| sampleTake | output | 1 | Input sample consumed this cycle |
| sfValid | output | 1 | New subframe present |
| sfData | output | 24 | Subframe sample word |
| sfChanB | output | 1 | 0 subframe A, 1 subframe B |
| sfBlockStart | output | 1 | First subframe of a channel status block |
| sfUser | output | 1 | User bit of the subframe |
| blkStartOut | output | 1 | Block-start reference driven out in master mode |
| blkStartDrive | output | 1 | Output enable for `blkStartOut` |

## Verification
The checker watches, on every cycle, the properties that hold at the ports regardless of history:
- the valid pulse follows a tick, and outputs stay stable between ticks;
- A and B alternate, and block start appears only on A;
- `sampleTake` is confined to tick cycles;
- `blkStartOut` is gated by its enable;
- the user bit is forced to zero when that mode is on.

Other behaviour depends on data and on counts over long spans, so only the bench's scenarios can show it:
- which sample lands in which slot in stereo and in mono;
- the 192-frame wrap;
- resynchronisation from an external edge;
- that the external edge is ignored in master mode.

// File: rtl/aes3SeqPkg.sv
package aes3SeqPkg;
  // Per-slot strobes from the sequencing control to the datapath
  typedef struct packed {
    logic emit;      // present a new subframe
    logic chanB;     // slot is subframe B
    logic grabPair;  // stereo A slot: take left, hold right
    logic grabMono;  // mono slot: take one sample of the chosen channel
    logic firstSub;  // first subframe of a status block
  } seqStrobe_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import aes3SeqPkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotTick,
  input  logic       monoMode,
  input  logic       blockMaster,
  input  logic       extBlkStart,
  output seqStrobe_t strobe
);
  localparam int CNT_W = $clog2(BLOCK_FRAMES);
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(BLOCK_FRAMES - 1);

  logic             slotB;
  logic [CNT_W-1:0] frameCnt;
  logic             extPrev;
  logic             syncPend;
  logic             extRise;
  logic             syncNow;
  logic [CNT_W-1:0] effFrame;

  assign extRise  = extBlkStart & ~extPrev & ~blockMaster;
  assign syncNow  = syncPend | extRise;
  assign effFrame = (!slotB && syncNow) ? '0 : frameCnt;

  always_comb begin
    strobe.emit     = slotTick;
    strobe.chanB    = slotB;
    strobe.grabPair = slotTick & ~monoMode & ~slotB;
    strobe.grabMono = slotTick & monoMode;
    strobe.firstSub = ~slotB & (effFrame == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotB    <= 1'b0;
      frameCnt <= '0;
      extPrev  <= 1'b0;
      syncPend <= 1'b0;
    end else begin
      extPrev <= extBlkStart;
      if (blockMaster) begin
        syncPend <= 1'b0;
      end else if (slotTick && !slotB) begin
        syncPend <= 1'b0;
      end else if (extRise) begin
        syncPend <= 1'b1;
      end
      if (slotTick) begin
        slotB <= ~slotB;
        if (slotB) begin
          frameCnt <= (frameCnt == LAST_FRAME) ? '0 : frameCnt + CNT_W'(1);
        end else if (syncNow) begin
          frameCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/seqData.sv
module seqData
  import aes3SeqPkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                monoRight,
  input  logic                userZero,
  input  logic                userIn,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                sfValid,
  output logic [SAMPLE_W-1:0] sfData,
  output logic                sfChanB,
  output logic                sfBlockStart,
  output logic                sfUser
);
  logic [SAMPLE_W-1:0] heldRight;
  logic [SAMPLE_W-1:0] nextData;

  always_comb begin
    if (strobe.grabMono)      nextData = monoRight ? inRight : inLeft;
    else if (strobe.grabPair) nextData = inLeft;
    else                      nextData = heldRight;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sfValid      <= 1'b0;
      sfData       <= '0;
      sfChanB      <= 1'b0;
      sfBlockStart <= 1'b0;
      sfUser       <= 1'b0;
      heldRight    <= '0;
    end else begin
      sfValid <= strobe.emit;
      if (strobe.grabPair) heldRight <= inRight;
      if (strobe.emit) begin
        sfData       <= nextData;
        sfChanB      <= strobe.chanB;
        sfBlockStart <= strobe.firstSub;
        sfUser       <= userIn & ~userZero;
      end
    end
  end
endmodule

// File: rtl/aes3SubframeSeq.sv
module aes3SubframeSeq
  import aes3SeqPkg::*;
#(
  parameter int SAMPLE_W     = 24,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slotTick,
  input  logic                monoMode,
  input  logic                monoRight,
  input  logic                blockMaster,
  input  logic                extBlkStart,
  input  logic                userZero,
  input  logic                userIn,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                sampleTake,
  output logic                sfValid,
  output logic [SAMPLE_W-1:0] sfData,
  output logic                sfChanB,
  output logic                sfBlockStart,
  output logic                sfUser,
  output logic                blkStartOut,
  output logic                blkStartDrive
);
  seqStrobe_t strobe;

  seqCtrl #(.BLOCK_FRAMES(BLOCK_FRAMES)) uCtrl (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .monoMode(monoMode),
    .blockMaster(blockMaster), .extBlkStart(extBlkStart), .strobe(strobe)
  );

  seqData #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .monoRight(monoRight),
    .userZero(userZero), .userIn(userIn), .inLeft(inLeft), .inRight(inRight),
    .sfValid(sfValid), .sfData(sfData), .sfChanB(sfChanB),
    .sfBlockStart(sfBlockStart), .sfUser(sfUser)
  );

  assign sampleTake    = strobe.grabPair | strobe.grabMono;
  assign blkStartDrive = blockMaster;
  assign blkStartOut   = blockMaster & sfBlockStart;
endmodule

// File: rtl/seqChecker.sv
module seqChecker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                slotTick,
  input logic                userZero,
  input logic                sampleTake,
  input logic                sfValid,
  input logic [SAMPLE_W-1:0] sfData,
  input logic                sfChanB,
  input logic                sfBlockStart,
  input logic                sfUser,
  input logic                blkStartOut,
  input logic                blkStartDrive
);
  logic seenOne;
  logic lastChan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenOne  <= 1'b0;
      lastChan <= 1'b0;
    end else if (sfValid) begin
      seenOne  <= 1'b1;
      lastChan <= sfChanB;
    end
  end

  // R2
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotTick |=> sfValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> !sfValid);
  // R2
  hold_between_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sfValid |-> ($stable(sfData) && $stable(sfChanB) && $stable(sfUser)));
  // R3
  chan_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfValid && seenOne) |-> (sfChanB != lastChan));
  // R3
  first_is_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfValid && !seenOne) |-> !sfChanB);
  // R7
  block_on_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    sfBlockStart |-> !sfChanB);
  // R6
  take_in_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTake |-> slotTick);
  // R8
  out_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkStartOut |-> blkStartDrive);
  // R10
  user_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && userZero) |=> !sfUser);
endmodule

bind aes3SubframeSeq seqChecker #(.SAMPLE_W(SAMPLE_W)) uChk (
  .clk(clk), .rstN(rstN), .slotTick(slotTick), .userZero(userZero),
  .sampleTake(sampleTake), .sfValid(sfValid), .sfData(sfData),
  .sfChanB(sfChanB), .sfBlockStart(sfBlockStart), .sfUser(sfUser),
  .blkStartOut(blkStartOut), .blkStartDrive(blkStartDrive)
);

// File: tb/tb_aes3SubframeSeq.sv
module tb_aes3SubframeSeq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, slotTick, monoMode, monoRight, blockMaster, extBlkStart;
  logic userZero, userIn;
  logic [23:0] inLeft, inRight;
  logic sampleTake, sfValid, sfChanB, sfBlockStart, sfUser, blkStartOut, blkStartDrive;
  logic [23:0] sfData;

  aes3SubframeSeq dut (.*);

  int total = 0;
  int bad = 0;
  logic takeObs;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runSlot(input logic m, input logic mr, input logic uz, input logic u,
                         input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    monoMode = m; monoRight = mr; userZero = uz; userIn = u;
    inLeft = l; inRight = r; slotTick = 1'b1;
    #1 takeObs = sampleTake;
    @(negedge clk);
    slotTick = 1'b0;
    inLeft = 24'hDEAD01; inRight = 24'hDEAD02;
  endtask

  typedef struct packed {
    logic m, mr, uz, u;
    logic [23:0] l, r, ed;
    logic eb, ebk, eu, et;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0,1'b0,1'b0,1'b1,24'h111111,24'h222222,24'h111111,1'b0,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,24'h333333,24'h444444,24'h222222,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,24'h555555,24'h666666,24'h555555,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,24'h777777,24'h888888,24'h666666,1'b1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,24'h0A0A0A,24'h0B0B0B,24'h0A0A0A,1'b0,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,24'h0C0C0C,24'h0D0D0D,24'h0C0C0C,1'b1,1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b0,1'b1,24'h0E0E0E,24'h0F0F0F,24'h0F0F0F,1'b0,1'b0,1'b1,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,24'hABCDEF,24'h123456,24'h123456,1'b1,1'b0,1'b0,1'b1}
  };

  logic wdFired = 1'b0;
  initial begin
    #400000;
    wdFired = 1'b1;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; slotTick = 1'b0; monoMode = 1'b0; monoRight = 1'b0;
    blockMaster = 1'b1; extBlkStart = 1'b0; userZero = 1'b0; userIn = 1'b0;
    inLeft = '0; inRight = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check({sfValid, sfData, sfChanB, sfBlockStart, sfUser, blkStartOut} == '0, "R1 reset outputs",
          {sfValid, sfChanB, sfBlockStart, sfUser, blkStartOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sfValid == 1'b0 && sfData == '0, "R1 idle after reset", sfValid, 0);

    // Table walk: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 8; i++) begin
      runSlot(TBL[i].m, TBL[i].mr, TBL[i].uz, TBL[i].u, TBL[i].l, TBL[i].r);
      check(takeObs == TBL[i].et, "R6 sampleTake", takeObs, TBL[i].et);
      check(sfValid == 1'b1, "R2 valid pulse", sfValid, 1);
      check(sfData == TBL[i].ed, TBL[i].m ? "R5 mono data" : "R4 stereo data", sfData, TBL[i].ed);
      check(sfChanB == TBL[i].eb, "R3 channel tag", sfChanB, TBL[i].eb);
      check(sfBlockStart == TBL[i].ebk, "R7 block start", sfBlockStart, TBL[i].ebk);
      check(blkStartOut == TBL[i].ebk && blkStartDrive, "R8 master out", blkStartOut, TBL[i].ebk);
      check(sfUser == TBL[i].eu, "R10 user bit", sfUser, TBL[i].eu);
    end

    // R2 hold between slots
    @(negedge clk);
    check(sfValid == 1'b0, "R2 valid one cycle", sfValid, 0);
    check(sfData == 24'h123456 && sfChanB == 1'b1, "R2 held data", sfData, 24'h123456);
    check(takeObs == 1'b1 && sampleTake == 1'b0, "R6 no take idle", sampleTake, 0);

    // R7 wrap: frames 4..191 have no block start, then frame 0
    begin
      int seen = 0;
      for (int f = 4; f < 192; f++) begin
        runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
        if (sfBlockStart) seen++;
        runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
        if (sfBlockStart) seen++;
      end
      check(seen == 0, "R7 no block start mid block", seen, 0);
    end
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(sfBlockStart == 1'b1 && sfChanB == 1'b0, "R7 wrap to frame 0", sfBlockStart, 1);
    @(negedge clk);
    check(blkStartOut == 1'b1, "R8 out held whole subframe", blkStartOut, 1);
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(blkStartOut == 1'b0, "R8 out low on B", blkStartOut, 0);

    // R9 external edge ignored in master mode (next A is frame 1)
    @(negedge clk); extBlkStart = 1'b1;
    repeat (2) @(negedge clk); extBlkStart = 1'b0;
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(sfBlockStart == 1'b0, "R9 edge ignored in master", sfBlockStart, 0);
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);

    // R9 slave resync: A (frame 2), edge, B, then A becomes frame 0
    blockMaster = 1'b0;
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(sfBlockStart == 1'b0 && blkStartDrive == 1'b0, "R8 slave no drive", blkStartDrive, 0);
    @(negedge clk); extBlkStart = 1'b1;
    repeat (2) @(negedge clk); extBlkStart = 1'b0;
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(sfBlockStart == 1'b0 && sfChanB == 1'b1, "R9 B slot unaffected", sfBlockStart, 0);
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(sfBlockStart == 1'b1 && sfChanB == 1'b0, "R9 resync block start", sfBlockStart, 1);
    check(blkStartOut == 1'b0, "R8 slave out low", blkStartOut, 0);
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    runSlot(1'b0, 1'b0, 1'b0, 1'b0, 24'h1, 24'h2);
    check(sfBlockStart == 1'b0, "R9 counting resumes at frame 1", sfBlockStart, 0);

    if (!wdFired) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule